// File: doc/BRIEF.md
# Rounding Saturating Fixed-Point Packer

This block sits at the write side of a memory column that stores narrow fixed-point numbers. It takes one signed 16-bit compute result per handshake and reduces it to a signed storage value of P bits, where P is chosen per value anywhere from 1 to 16. A second setting tells it how many low-order bits of the input are fractional bits to discard. The reduced value is rounded to nearest and clamped to the P-bit range. It is then appended to a continuous bit stream that fills 16-bit memory words from the least significant bit upward.

The stream is kept in a 32-bit circular packing register made of two 16-bit halves. Each value is rotated to the current fill position and written under a bit-enable mask, so a value may start in one half and finish in the other, including across the wrap from bit 31 back to bit 0. As soon as a half has no free bits left, it is handed out as one word. A flush request pushes out a partly filled word with zeros in its empty bits and starts the stream over at bit 0.

Top module: `fxp_packer`

## Requirements
- R1: After synchronous active-low reset, `out_valid` is low, `in_ready` is high, and the first accepted value lands at bit 0 of the first output word.
- R2: With `cfg_drop` = D > 0, the input is divided by 2^D and rounded to nearest, with exact halves moving away from zero (24 → 2, −24 → −2, 23 → 1, 8 → 1, −8 → −1 for D = 4). With D = 0 the input passes through unchanged.
- R3: After rounding, a value above 2^(P−1)−1 becomes 2^(P−1)−1 and a value below −2^(P−1) becomes −2^(P−1), where P = `cfg_width`. For P = 1 the only codes are 0 and −1.
- R4: The P two's-complement bits of each value follow the previous value's bits with no gap. In each output word, bit 0 is the earliest bit, and a value may be split across two consecutive words.
- R5: A word is presented on `out_valid`/`out_data` in the cycle after the handshake that completes its 16th bit. `out_valid` never rises unless an input or a flush was taken in the previous cycle.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` does not change.
- R7: `in_ready` is low exactly when an output word is pending and `out_ready` is low, or when `flush` is high. No emitted word is ever lost.
- R8: A flush is taken in any cycle where no word is blocked. If unemitted bits exist, they come out as one word with the remaining high bits zero; if none exist, no word is produced. In both cases the next value starts at bit 0 of a new word.
- R9: `cfg_width` and `cfg_drop` may change between any two values, and each value uses the setting present in the cycle it is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_width | input | 5 | Storage width P of the value being offered (1..16) |
| cfg_drop | input | 4 | Number of fractional input bits to round away (0..15) |
| in_valid | input | 1 | Input value offered |
| in_data | input | 16 | Signed fixed-point input value |
| in_ready | output | 1 | Block can take a value this cycle |
| flush | input | 1 | Request to emit any partial word and restart at bit 0 |
| out_valid | output | 1 | Packed word available |
| out_data | output | 16 | Packed storage word |
| out_ready | input | 1 | Receiver takes the word this cycle |

## Verification
The bench builds the block with its default 16-bit data width. This gives a 32-bit circular register with a 5-bit fill pointer, so every fill position and both half boundaries occur within a few hundred values. Because P ranges over all of 1 to 16 and the drop count over 0 to 15, the random phase reaches single-bit storage, full-width pass-through, and values that wrap from bit 31 to bit 0. Hand-picked values cover the rounding ties at the 4-bit drop, saturation applied after rounding at P = 8, and the exact bit layout of three 12-bit values that straddle two words and leave a 4-bit tail for a flush.

// File: rtl/pk_pkg.sv
// Package: shared types for the fixed-point packer.
// Assumes nothing beyond being compiled before the modules that import it.
package pk_pkg;
    // Which output word, if any, a cycle produces.
    typedef enum logic [1:0] {
        EV_NONE  = 2'd0,
        EV_LO    = 2'd1,
        EV_HI    = 2'd2,
        EV_FLUSH = 2'd3
    } emit_e;
endpackage

// File: rtl/pk_round_sat.sv
// Module: pk_round_sat
// Reduces a signed DATA_W-bit input by dropping `drop` low bits. Rounds to
// nearest with ties moving away from zero, then clamps to the signed range
// of `width` bits. The result is a sign-extended value of DATA_W+2 bits.
// Assumes 1 <= width <= DATA_W; purely combinational.
module pk_round_sat #(
    parameter int DATA_W = 16,
    parameter int DROP_W = $clog2(DATA_W),
    parameter int WID_W  = $clog2(DATA_W) + 1,
    localparam int EXT_W = DATA_W + 2
) (
    input  logic [DATA_W-1:0] din,
    input  logic [DROP_W-1:0] drop,
    input  logic [WID_W-1:0]  width,
    output logic [EXT_W-1:0]  q
);
    logic signed [EXT_W-1:0] v, mag, bias, rmag, rnd, lim, hi, lo;
    logic                    neg;

    // Round the magnitude, restore the sign, then clamp to the P-bit range.
    always_comb begin
        neg  = din[DATA_W-1];
        v    = {{2{din[DATA_W-1]}}, din};
        mag  = neg ? -v : v;
        bias = (drop == '0) ? '0 : (EXT_W'(1) <<< (drop - 1'b1));
        rmag = (mag + bias) >>> drop;
        rnd  = neg ? -rmag : rmag;
        lim  = EXT_W'(1) <<< (width - 1'b1);
        hi   = lim - EXT_W'(1);
        lo   = -lim;
        if (rnd > hi)      q = hi;
        else if (rnd < lo) q = lo;
        else               q = rnd;
    end
endmodule

// File: rtl/pk_align.sv
// Module: pk_align
// Keeps the low `width` bits of a value and rotates them left by `ptr`
// inside a 2*DATA_W-bit ring. It also produces the matching write-enable
// mask and reports whether this write fills the last bit of either half.
// Assumes DATA_W is a power of two and 1 <= width <= DATA_W.
module pk_align #(
    parameter int DATA_W = 16,
    parameter int VAL_W  = DATA_W + 2,
    parameter int WID_W  = $clog2(DATA_W) + 1,
    localparam int REG_W = 2 * DATA_W,
    localparam int PTR_W = $clog2(REG_W)
) (
    input  logic [VAL_W-1:0] val,
    input  logic [PTR_W-1:0] ptr,
    input  logic [WID_W-1:0] width,
    output logic [REG_W-1:0] rot,
    output logic [REG_W-1:0] mask,
    output logic             fill_lo,
    output logic             fill_hi
);
    localparam logic [PTR_W:0] LO_END = (PTR_W+1)'(DATA_W - 1);
    localparam logic [PTR_W:0] HI_END = (PTR_W+1)'(REG_W - 1);

    logic [REG_W-1:0] base, vext;
    logic [PTR_W:0]   end_pos;

    // Trim the value to P bits and find the last ring position it occupies.
    always_comb begin
        base    = ~({REG_W{1'b1}} << width);
        vext    = {{(REG_W-VAL_W){1'b0}}, val} & base;
        end_pos = {1'b0, ptr} + (PTR_W+1)'(width) - 1'b1;
        fill_lo = !ptr[PTR_W-1] && (end_pos >= LO_END);
        fill_hi = end_pos >= HI_END;
    end

    // Each ring bit picks its source bit at (j - ptr) modulo the ring size.
    for (genvar j = 0; j < REG_W; j++) begin : g_rot
        assign rot[j]  = vext[PTR_W'(j) - ptr];
        assign mask[j] = base[PTR_W'(j) - ptr];
    end
endmodule

// File: rtl/fxp_packer.sv
// Module: fxp_packer
// Converts signed DATA_W-bit results into P-bit rounded, saturated codes and
// packs them LSB-first into DATA_W-bit words held in a two-half ring. Each
// half is emitted when full; a flush emits a zero-padded partial half.
// Assumes DATA_W is a power of two and cfg_width lies in 1..DATA_W.
module fxp_packer #(
    parameter int DATA_W = 16,
    localparam int DROP_W = $clog2(DATA_W),
    localparam int WID_W  = $clog2(DATA_W) + 1,
    localparam int VAL_W  = DATA_W + 2,
    localparam int REG_W  = 2 * DATA_W,
    localparam int PTR_W  = $clog2(REG_W),
    localparam int SUB_W  = PTR_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WID_W-1:0]  cfg_width,
    input  logic [DROP_W-1:0] cfg_drop,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    input  logic              flush,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    input  logic              out_ready
);
    import pk_pkg::*;

    localparam logic [REG_W-1:0] LO_HALF = {{DATA_W{1'b0}}, {DATA_W{1'b1}}};
    localparam logic [REG_W-1:0] HI_HALF = {{DATA_W{1'b1}}, {DATA_W{1'b0}}};

    logic [VAL_W-1:0]  q;
    logic [REG_W-1:0]  rot, mask, pack, merged, nxt_pack;
    logic [PTR_W-1:0]  ptr, nxt_ptr;
    logic [DATA_W-1:0] word;
    logic              fill_lo, fill_hi, out_free, take, flush_take;
    emit_e             emit;

    pk_round_sat #(.DATA_W(DATA_W), .DROP_W(DROP_W), .WID_W(WID_W)) u_round (
        .din   (in_data),
        .drop  (cfg_drop),
        .width (cfg_width),
        .q     (q)
    );

    pk_align #(.DATA_W(DATA_W), .VAL_W(VAL_W), .WID_W(WID_W)) u_align (
        .val     (q),
        .ptr     (ptr),
        .width   (cfg_width),
        .rot     (rot),
        .mask    (mask),
        .fill_lo (fill_lo),
        .fill_hi (fill_hi)
    );

    // Handshake: nothing is taken while a finished word is blocked.
    always_comb begin
        out_free   = !out_valid || out_ready;
        in_ready   = out_free && !flush;
        take       = in_valid && in_ready;
        flush_take = flush && out_free;
    end

    // Next ring contents, fill pointer and the word (if any) this cycle yields.
    always_comb begin
        merged   = (pack & ~mask) | (rot & mask);
        nxt_pack = pack;
        nxt_ptr  = ptr;
        emit     = EV_NONE;
        if (flush_take) begin
            nxt_pack = '0;
            nxt_ptr  = '0;
            if (ptr[SUB_W-1:0] != '0) emit = EV_FLUSH;
        end else if (take) begin
            nxt_ptr = ptr + PTR_W'(cfg_width);
            if (fill_lo) begin
                emit     = EV_LO;
                nxt_pack = merged & ~LO_HALF;
            end else if (fill_hi) begin
                emit     = EV_HI;
                nxt_pack = merged & ~HI_HALF;
            end else begin
                nxt_pack = merged;
            end
        end
        case (emit)
            EV_LO:    word = merged[DATA_W-1:0];
            EV_HI:    word = merged[REG_W-1:DATA_W];
            EV_FLUSH: word = ptr[PTR_W-1] ? pack[REG_W-1:DATA_W] : pack[DATA_W-1:0];
            default:  word = out_data;
        endcase
    end

    // State update for the ring, pointer and output word register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pack      <= '0;
            ptr       <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            pack <= nxt_pack;
            ptr  <= nxt_ptr;
            if (emit != EV_NONE) begin
                out_valid <= 1'b1;
                out_data  <= word;
            end else if (out_ready) begin
                out_valid <= 1'b0;
            end
        end
    end

    // R6: a blocked word holds still
    a_r6_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

    // R7: no input is taken over a blocked word
    a_r7_stall_input: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |-> !in_ready);

    // R7: flush blocks new data
    a_r7_flush_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !in_ready);

    // R4: the write enable covers exactly P bits
    a_r4_mask_bits: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> $countones(mask) == int'(cfg_width));

    // R5: a word only appears after a taken input or flush
    a_r5_word_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(take || flush_take));

    // R8: a flush over unemitted bits yields a word
    a_r8_flush_word: assert property (@(posedge clk) disable iff (!rst_n)
        flush_take && (ptr[SUB_W-1:0] != '0) |=> out_valid);
endmodule

// File: tb/test_fxp_packer.sv
module test_fxp_packer;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [4:0]  cfg_width;
    logic [3:0]  cfg_drop;
    logic        in_valid, flush, out_ready;
    logic [15:0] in_data;
    logic        in_ready, out_valid;
    logic [15:0] out_data;

    int          total = 0;
    int          bad = 0;
    bit          done = 0;
    bit          bq[$];
    logic [15:0] got[$];
    logic        exp_valid = 1'b0;
    logic [15:0] exp_data = '0;
    bit          acc, ftk;

    fxp_packer i_fxp_packer (
        .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width), .cfg_drop(cfg_drop),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready), .flush(flush),
        .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Rounded (ties away from zero) then clamped value, computed from R2/R3.
    function automatic int qref(int x, int d, int p);
        int r;
        if (d == 0) r = x;
        else if (x >= 0) r = (x + (1 << (d - 1))) >>> d;
        else r = -((-x + (1 << (d - 1))) >>> d);
        if (r > (1 << (p - 1)) - 1) r = (1 << (p - 1)) - 1;
        if (r < -(1 << (p - 1))) r = -(1 << (p - 1));
        return r;
    endfunction

    function automatic logic [15:0] pop_word();
        logic [15:0] w;
        for (int i = 0; i < 16; i++) w[i] = bq.pop_front();
        return w;
    endfunction

    // One clock: drive, predict the next output state, compare after the edge.
    task automatic cycle(bit v, logic [15:0] d, bit fl, bit ordy, string tag);
        bit          free;
        logic        nv;
        logic [15:0] nd;
        int          r;
        in_valid = v; in_data = d; flush = fl; out_ready = ordy;
        #1;
        free = !(exp_valid && !ordy);
        chk(in_ready == (free && !fl), "R7", "in_ready", in_ready, free && !fl);
        nv = exp_valid && !ordy;
        nd = exp_data;
        acc = 0; ftk = 0;
        if (out_valid && ordy) got.push_back(out_data);
        if (fl && free) begin
            ftk = 1;
            if (bq.size() > 0) begin
                while (bq.size() < 16) bq.push_back(1'b0);
                nd = pop_word(); nv = 1'b1;
            end
        end else if (v && free) begin
            acc = 1;
            r = qref(int'($signed(d)), int'(cfg_drop), int'(cfg_width));
            for (int b = 0; b < int'(cfg_width); b++) bq.push_back(r[b]);
            if (bq.size() >= 16) begin nd = pop_word(); nv = 1'b1; end
        end
        @(posedge clk);
        exp_valid = nv; exp_data = nd;
        @(negedge clk);
        chk(out_valid == exp_valid, tag, "out_valid", out_valid, exp_valid);
        if (exp_valid) chk(out_data == exp_data, tag, "out_data", out_data, exp_data);
    endtask

    task automatic send(int val, int p, int d, string tag, int pct);
        cfg_width = 5'(p); cfg_drop = 4'(d);
        do cycle(1'b1, 16'(val), 1'b0, ($urandom % 100) < pct, tag); while (!acc);
    endtask

    task automatic flush_now(string tag, int pct);
        do cycle(1'b0, 16'h0, 1'b1, ($urandom % 100) < pct, tag); while (!ftk);
    endtask

    task automatic drain(string tag);
        cycle(1'b0, 16'h0, 1'b0, 1'b1, tag);
        while (exp_valid) cycle(1'b0, 16'h0, 1'b0, 1'b1, tag);
    endtask

    task automatic expect_words(string tag, logic [15:0] e[]);
        chk(got.size() == e.size(), tag, "word count", got.size(), e.size());
        if (got.size() == e.size())
            foreach (e[i]) chk(got[i] == e[i], tag, "packed word", got[i], e[i]);
        got.delete();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; in_valid = 0; in_data = '0; flush = 0; out_ready = 1;
        cfg_width = 5'd16; cfg_drop = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(out_valid == 1'b0, "R1", "reset out_valid", out_valid, 0);
        chk(in_ready == 1'b1, "R1", "reset in_ready", in_ready, 1);
        rst_n = 1'b1;

        // R2: rounding ties and drop count, one value per word at P=16
        got.delete();
        send(24, 16, 4, "R2", 100); send(-24, 16, 4, "R2", 100);
        send(23, 16, 4, "R2", 100); send(-23, 16, 4, "R2", 100);
        send(8, 16, 4, "R2", 100);  send(-8, 16, 4, "R2", 100);
        drain("R2");
        expect_words("R2", '{16'h0002, 16'hFFFE, 16'h0001, 16'hFFFF, 16'h0001, 16'hFFFF});

        // R3: clamp at P=8, clamp after rounding, and P=1
        send(32767, 8, 0, "R3", 100); send(-32768, 8, 0, "R3", 100);
        send(2056, 8, 4, "R3", 100);  send(-2056, 8, 4, "R3", 100);
        for (int i = 0; i < 16; i++) send((i % 2) ? 5 : -5, 1, 0, "R3", 100);
        drain("R3");
        expect_words("R3", '{16'h807F, 16'h807F, 16'h5555});

        // R4/R8: 12-bit values straddling words, wrap, zero-padded flush
        send(16'h123, 12, 0, "R4", 100); send(16'h456, 12, 0, "R4", 100);
        send(16'h789, 12, 0, "R4", 100);
        flush_now("R8", 100);
        drain("R8");
        expect_words("R4", '{16'h6123, 16'h8945, 16'h0007});

        // R8: flush with nothing pending yields no word; next value at bit 0
        flush_now("R8", 100);
        drain("R8");
        send(-1, 4, 0, "R8", 100); flush_now("R8", 100); drain("R8");
        expect_words("R8", '{16'h000F});

        // R6/R7: heavy back-pressure
        for (int i = 0; i < 20; i++) send(i * 1111 - 9000, 16, 0, "R6", 15);
        for (int i = 0; i < 20; i++) send(i * 777, 9, 2, "R7", 25);
        flush_now("R7", 30); drain("R7"); got.delete();

        // R9/R5: per-value width and drop changes, random ready and flushes
        for (int i = 0; i < 400; i++) begin
            send(int'($urandom % 65536), 1 + int'($urandom % 16), int'($urandom % 16), "R9", 60);
            if ($urandom % 20 == 0) flush_now("R5", 60);
        end
        flush_now("R9", 60);
        drain("R9");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule